// File: doc/BRIEF.md
# Index Pointer Register File

This block keeps four 16-bit address pointers for a small processor core. Each pointer is made of two byte registers, and those bytes also sit in the general register space at fixed register numbers. Software loads and inspects a pointer one byte at a time through an 8-bit register port. An instruction that reads or writes data memory through a pointer, or jumps to an address held in one, names a pointer and an update mode. The block then presents the 16-bit address and writes back the stepped pointer.

Only some of the pointer bytes can be reached by an immediate-mode register write. One instruction form ignores the pointer select and always uses the last pointer. The ALU, the instruction decoder and the memories are outside this block.

Top module: `idxPtrFile`

## Requirements
- R1: After reset every pointer holds 0, so all eight pointer bytes read back as 0x00.
- R2: Register number 12+2k reads the low byte and 13+2k reads the high byte of pointer k (k = 0..3), and the value appears on regRdData in the same cycle. Any register number outside 12..19 reads as 0x00.
- R3: A write with regWrEn=1 and regImm=0 to a register number in 12..19 replaces that byte on the next clock edge and leaves the other byte unchanged. A write to a number outside 12..19 changes no pointer.
- R4: A write with regImm=1 only takes effect for register numbers below 16, so it can reach pointers 0 and 1 only. Immediate writes to 16..19 are ignored.
- R5: The pointer accessed is selected by accSel. When accMode=0 (hold), addrOut equals that pointer and the pointer does not change. This mode also serves indirect jumps to any of the four pointers.
- R6: accMode=1 (pre-increment) with accEn=1 drives addrOut with pointer+1 in the same cycle and stores pointer+1.
- R7: accMode=2 (post-increment) with accEn=1 drives addrOut with the old pointer and stores pointer+1.
- R8: accMode=3 (post-decrement) with accEn=1 drives addrOut with the old pointer and stores pointer-1.
- R9: Stepping wraps modulo 2^16: 0xFFFF+1 gives 0x0000, and 0x0000-1 gives 0xFFFF.
- R10: With accFixZ=1 the access uses pointer 3 whatever accSel is.
- R11: If a byte write hits the pointer being stepped in the same cycle, the byte write wins. That pointer keeps its other byte unstepped. A step of a different pointer in the same cycle still takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| regAddr | input | 5 | Register number for byte read and write |
| regWrEn | input | 1 | Byte write strobe |
| regImm | input | 1 | Write comes from an immediate-mode instruction |
| regWrData | input | 8 | Byte to write |
| regRdData | output | 8 | Byte at regAddr, 0 outside 12..19 |
| accEn | input | 1 | Indirect access active, enables the pointer step |
| accSel | input | 2 | Pointer select |
| accMode | input | 2 | 0 hold, 1 pre-increment, 2 post-increment, 3 post-decrement |
| accFixZ | input | 1 | Force pointer 3 |
| addrOut | output | 16 | Address for memory access or jump |

## Verification
A byte write through the register port and a pointer step can land in the same cycle, either on the same pointer or on different ones. The bench steps pointer 1 with post-increment while it writes the low byte of pointer 1. It then repeats the write while stepping pointer 2. Afterwards it reads all bytes back: the first pointer must show the written low byte beside its old high byte, and the second must show its stepped value.

// File: rtl/idxPtrPkg.sv
package idxPtrPkg;
  localparam int PTR_CNT   = 4;
  localparam int BYTE_W    = 8;
  localparam int PTR_W     = 2 * BYTE_W;
  localparam int SEL_W     = $clog2(PTR_CNT);
  localparam int REG_AW    = 5;
  localparam int REG_BASE  = 12;
  localparam int REG_SPAN  = 2 * PTR_CNT;
  localparam int IMM_REACH = 16;

  typedef enum logic [1:0] {
    MODE_HOLD    = 2'd0,
    MODE_PREINC  = 2'd1,
    MODE_POSTINC = 2'd2,
    MODE_POSTDEC = 2'd3
  } accMode_e;

  typedef struct packed {
    logic [PTR_CNT-1:0] updEn;
    logic [PTR_CNT-1:0] wrLo;
    logic [PTR_CNT-1:0] wrHi;
    logic [SEL_W-1:0]   outSel;
    logic               outNext;
    logic               stepDown;
    logic               rdValid;
    logic [SEL_W-1:0]   rdIdx;
    logic               rdHi;
  } ptrStrobe_t;
endpackage

// File: rtl/idxPtrCtrl.sv
module idxPtrCtrl
  import idxPtrPkg::*;
(
  input  logic [REG_AW-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              regImm,
  input  logic              accEn,
  input  logic [SEL_W-1:0]  accSel,
  input  logic [1:0]        accMode,
  input  logic              accFixZ,
  output ptrStrobe_t        strobe
);
  localparam logic [REG_AW-1:0] BASE_A  = REG_AW'(REG_BASE);
  localparam logic [REG_AW-1:0] LIMIT_A = REG_AW'(REG_BASE + REG_SPAN);
  localparam logic [REG_AW-1:0] IMM_A   = REG_AW'(IMM_REACH);

  logic [REG_AW-1:0] offs;
  logic              inRange;
  logic              wrOk;
  logic [SEL_W-1:0]  hitIdx;
  logic              hitHi;
  logic [SEL_W-1:0]  effSel;
  accMode_e          modeE;

  always_comb begin
    offs    = regAddr - BASE_A;
    inRange = (regAddr >= BASE_A) && (regAddr < LIMIT_A);
    hitIdx  = offs[SEL_W:1];
    hitHi   = offs[0];
    wrOk    = regWrEn && inRange && (!regImm || (regAddr < IMM_A));
    effSel  = accFixZ ? SEL_W'(PTR_CNT - 1) : accSel;
    modeE   = accMode_e'(accMode);
  end

  always_comb begin
    strobe          = '0;
    strobe.outSel   = effSel;
    strobe.outNext  = (modeE == MODE_PREINC);
    strobe.stepDown = (modeE == MODE_POSTDEC);
    strobe.rdValid  = inRange;
    strobe.rdIdx    = hitIdx;
    strobe.rdHi     = hitHi;
    for (int k = 0; k < PTR_CNT; k++) begin
      strobe.wrLo[k]  = wrOk && (hitIdx == SEL_W'(k)) && !hitHi;
      strobe.wrHi[k]  = wrOk && (hitIdx == SEL_W'(k)) && hitHi;
      strobe.updEn[k] = accEn && (modeE != MODE_HOLD) && (effSel == SEL_W'(k))
                        && !(wrOk && (hitIdx == SEL_W'(k)));
    end
  end
endmodule

// File: rtl/idxPtrData.sv
module idxPtrData
  import idxPtrPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ptrStrobe_t        strobe,
  input  logic [BYTE_W-1:0] wrData,
  output logic [BYTE_W-1:0] rdData,
  output logic [PTR_W-1:0]  addrOut
);
  logic [PTR_W-1:0] ptrQ    [PTR_CNT];
  logic [PTR_W-1:0] stepVal [PTR_CNT];

  for (genvar k = 0; k < PTR_CNT; k++) begin : g_ptr
    assign stepVal[k] = strobe.stepDown ? ptrQ[k] - PTR_W'(1) : ptrQ[k] + PTR_W'(1);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ptrQ[k] <= '0;
      end else if (strobe.wrLo[k]) begin
        ptrQ[k][BYTE_W-1:0] <= wrData;
      end else if (strobe.wrHi[k]) begin
        ptrQ[k][PTR_W-1:BYTE_W] <= wrData;
      end else if (strobe.updEn[k]) begin
        ptrQ[k] <= stepVal[k];
      end
    end
  end

  always_comb begin
    if (!strobe.rdValid)  rdData = '0;
    else if (strobe.rdHi) rdData = ptrQ[strobe.rdIdx][PTR_W-1:BYTE_W];
    else                  rdData = ptrQ[strobe.rdIdx][BYTE_W-1:0];
    addrOut = strobe.outNext ? stepVal[strobe.outSel] : ptrQ[strobe.outSel];
  end
endmodule

// File: rtl/idxPtrFile.sv
module idxPtrFile
  import idxPtrPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_AW-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              regImm,
  input  logic [BYTE_W-1:0] regWrData,
  output logic [BYTE_W-1:0] regRdData,
  input  logic              accEn,
  input  logic [SEL_W-1:0]  accSel,
  input  logic [1:0]        accMode,
  input  logic              accFixZ,
  output logic [PTR_W-1:0]  addrOut
);
  ptrStrobe_t strobe;

  idxPtrCtrl ctrl_i (
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .regImm  (regImm),
    .accEn   (accEn),
    .accSel  (accSel),
    .accMode (accMode),
    .accFixZ (accFixZ),
    .strobe  (strobe)
  );

  idxPtrData data_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wrData  (regWrData),
    .rdData  (regRdData),
    .addrOut (addrOut)
  );
endmodule

// File: rtl/idxPtrChk.sv
module idxPtrChk
  import idxPtrPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [REG_AW-1:0] regAddr,
  input logic              regWrEn,
  input logic              regImm,
  input logic [BYTE_W-1:0] regRdData,
  input logic              accEn,
  input logic [SEL_W-1:0]  accSel,
  input logic [1:0]        accMode,
  input logic              accFixZ,
  input logic [PTR_W-1:0]  addrOut
);
  logic [SEL_W-1:0] chkSel;
  assign chkSel = accFixZ ? SEL_W'(PTR_CNT - 1) : accSel;

  AST_RD_OUTSIDE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ((regAddr < REG_AW'(REG_BASE)) || (regAddr >= REG_AW'(REG_BASE + REG_SPAN))) |-> (regRdData == '0)); // R2

  AST_IMM_NO_REACH: assert property (@(posedge clk) disable iff (!rstN)
    ($past(regWrEn && regImm && (regAddr >= REG_AW'(IMM_REACH))) && !$past(accEn)
     && (regAddr == $past(regAddr))) |-> (regRdData == $past(regRdData))); // R4

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    ($past(accEn && (accMode == 2'd0) && !regWrEn) && accEn && (accMode == 2'd0)
     && (chkSel == $past(chkSel))) |-> (addrOut == $past(addrOut))); // R5

  AST_PREINC_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    ($past(accEn && (accMode == 2'd1) && !regWrEn) && accEn && (accMode == 2'd0)
     && (chkSel == $past(chkSel))) |-> (addrOut == $past(addrOut))); // R6

  AST_POSTINC_STEP: assert property (@(posedge clk) disable iff (!rstN)
    ($past(accEn && (accMode == 2'd2) && !regWrEn) && accEn && (accMode == 2'd0)
     && (chkSel == $past(chkSel))) |-> (addrOut == PTR_W'($past(addrOut) + PTR_W'(1)))); // R7

  AST_POSTDEC_STEP: assert property (@(posedge clk) disable iff (!rstN)
    ($past(accEn && (accMode == 2'd3) && !regWrEn) && accEn && (accMode == 2'd0)
     && (chkSel == $past(chkSel))) |-> (addrOut == PTR_W'($past(addrOut) - PTR_W'(1)))); // R8
endmodule

bind idxPtrFile idxPtrChk chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .regAddr   (regAddr),
  .regWrEn   (regWrEn),
  .regImm    (regImm),
  .regRdData (regRdData),
  .accEn     (accEn),
  .accSel    (accSel),
  .accMode   (accMode),
  .accFixZ   (accFixZ),
  .addrOut   (addrOut)
);

// File: tb/idxPtrFile_tb.sv
module idxPtrFile_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic        regImm = 1'b0;
  logic [7:0]  regWrData = '0;
  logic [7:0]  regRdData;
  logic        accEn = 1'b0;
  logic [1:0]  accSel = '0;
  logic [1:0]  accMode = '0;
  logic        accFixZ = 1'b0;
  logic [15:0] addrOut;

  int checks = 0;
  int errors = 0;
  logic [15:0] model [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  idxPtrFile dut_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn), .regImm(regImm),
    .regWrData(regWrData), .regRdData(regRdData), .accEn(accEn), .accSel(accSel),
    .accMode(accMode), .accFixZ(accFixZ), .addrOut(addrOut)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    regWrEn = 1'b0; regImm = 1'b0; accEn = 1'b0; accMode = 2'd0; accFixZ = 1'b0;
  endtask

  task automatic writeByte(input logic [4:0] a, input logic [7:0] d, input logic imm);
    @(negedge clk);
    idle();
    regAddr = a; regWrData = d; regImm = imm; regWrEn = 1'b1;
    @(posedge clk); #1;
    idle();
  endtask

  task automatic loadPtr(input int k, input logic [15:0] v);
    writeByte(5'(12 + 2*k), v[7:0], 1'b0);
    writeByte(5'(13 + 2*k), v[15:8], 1'b0);
    model[k] = v;
  endtask

  task automatic readPtr(input string req, input int k);
    logic [15:0] got;
    @(negedge clk);
    idle();
    regAddr = 5'(12 + 2*k); #1; got[7:0] = regRdData;
    regAddr = 5'(13 + 2*k); #1; got[15:8] = regRdData;
    check(req, got, model[k]);
  endtask

  // access with address check in the same cycle, model update from requirements
  task automatic access(input string req, input int sel, input int mode, input logic fix);
    int eff;
    logic [15:0] expAddr;
    eff = fix ? 3 : sel;
    case (mode)
      1:       expAddr = model[eff] + 16'd1;
      default: expAddr = model[eff];
    endcase
    @(negedge clk);
    idle();
    accEn = 1'b1; accSel = 2'(sel); accMode = 2'(mode); accFixZ = fix; #1;
    check(req, addrOut, expAddr);
    @(posedge clk); #1;
    idle();
    case (mode)
      1, 2: model[eff] = model[eff] + 16'd1;
      3:    model[eff] = model[eff] - 16'd1;
      default: ;
    endcase
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual running expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < 4; k++) model[k] = '0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1: reset state
    for (int k = 0; k < 4; k++) readPtr("R1", k);

    // R2: outside range reads zero
    for (int a = 0; a < 32; a++) begin
      if (a < 12 || a > 19) begin
        @(negedge clk); regAddr = 5'(a); #1;
        check("R2", 16'(regRdData), 16'h0000);
      end
    end

    // R3 / R2: byte mapping sweep
    for (int k = 0; k < 4; k++) loadPtr(k, 16'(16'hA15C + k * 16'h1213));
    for (int k = 0; k < 4; k++) readPtr("R2", k);
    writeByte(5'd13, 8'h77, 1'b0); model[0][15:8] = 8'h77;
    readPtr("R3", 0);
    for (int a = 0; a < 12; a++) writeByte(5'(a), 8'hEE, 1'b0);
    for (int a = 20; a < 32; a++) writeByte(5'(a), 8'hEE, 1'b0);
    for (int k = 0; k < 4; k++) readPtr("R3", k);

    // R4: immediate reach
    for (int a = 12; a < 20; a++) begin
      writeByte(5'(a), 8'(8'h30 + a), 1'b1);
      if (a < 16) begin
        if (a[0]) model[(a-12)/2][15:8] = 8'(8'h30 + a);
        else      model[(a-12)/2][7:0]  = 8'(8'h30 + a);
      end
    end
    for (int k = 0; k < 4; k++) readPtr("R4", k);

    // R5..R8: sweep of every pointer and mode, byte-boundary start values
    for (int k = 0; k < 4; k++) begin
      for (int m = 0; m < 4; m++) begin
        loadPtr(k, 16'(16'h00FF + k * 16'h1100 + (m == 3 ? 1 : 0)));
        case (m)
          0: access("R5", k, m, 1'b0);
          1: access("R6", k, m, 1'b0);
          2: access("R7", k, m, 1'b0);
          default: access("R8", k, m, 1'b0);
        endcase
        access("R5", k, 0, 1'b0);
        for (int j = 0; j < 4; j++) readPtr("R5", j);
      end
    end

    // R9: wrap
    loadPtr(2, 16'hFFFF); access("R9", 2, 2, 1'b0); readPtr("R9", 2);
    access("R9", 2, 3, 1'b0); readPtr("R9", 2);
    access("R9", 2, 1, 1'b0); readPtr("R9", 2);

    // R10: forced pointer 3
    loadPtr(3, 16'h4000); loadPtr(0, 16'h1234);
    for (int s = 0; s < 4; s++) access("R10", s, 2, 1'b1);
    for (int k = 0; k < 4; k++) readPtr("R10", k);

    // R11: byte write and step in the same cycle
    loadPtr(1, 16'h2080); loadPtr(2, 16'h3000);
    @(negedge clk); idle();
    regAddr = 5'd14; regWrData = 8'h5A; regWrEn = 1'b1;
    accEn = 1'b1; accSel = 2'd1; accMode = 2'd2;
    @(posedge clk); #1; idle();
    model[1] = 16'h205A;
    readPtr("R11", 1);
    @(negedge clk); idle();
    regAddr = 5'd14; regWrData = 8'hC3; regWrEn = 1'b1;
    accEn = 1'b1; accSel = 2'd2; accMode = 2'd2;
    @(posedge clk); #1; idle();
    model[1] = 16'h20C3; model[2] = 16'h3001;
    readPtr("R11", 1);
    readPtr("R11", 2);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule